// File: doc/BRIEF.md
# Mode-Dependent Memory Map Decoder

This block turns a 16-bit CPU bus address into one-hot selects for four targets: the internal register block, the internal nonvolatile store (EEPROM), the bootstrap ROM and the external bus. Two mode pins are sampled while reset is held. They give the starting value of a mode register with four flags: boot ROM enable, special mode, expanded bus and internal-read visibility. Software can later rewrite some of these flags. Where the EEPROM sits depends on the expanded flag and on a configuration byte that is copied from its nonvolatile cell at reset.

In special modes, vector fetches that target the top 64 bytes of the map are moved down by 16 KB. The block also enforces the write rules for the lock and configuration registers. A configuration write that is accepted is passed to the cell through a program strobe. It changes the decode only after the next reset.

Top module: `memMapDecoder`

## Requirements
- R1: While rstN is low, the mode pins {modePinA, modePinB} set the mode flags. 11 gives normal expanded (expanded only). 00 gives bootstrap (boot ROM and special). 10 gives special test (special and expanded). 01 gives single-chip (no flag set). The visibility flag and the lock bit reset to 0 and 1.
- R2: Any access to $1000-$103F asserts selRegs only. The register block takes precedence over every other target.
- R3: While the expanded flag is clear, the EEPROM is always enabled at $FE00-$FFFF, whatever the configuration byte holds, and selExt never asserts.
- R4: While the expanded flag is set, the EEPROM occupies the top 512 bytes of the 4 KB page chosen by config bits [7:4]. Config bit 0 = 0 disables the EEPROM.
- R5: The configuration byte used for decoding is copied from cfgCell only while reset is held. It stays fixed between resets.
- R6: When the boot ROM flag is set, $BF00-$BFFF selects the boot ROM, unless the register block or the EEPROM claims the address.
- R7: When the special flag is set and vecFetch is high, an address in $FFC0-$FFFF is moved down by $4000. In every other case mappedAddr equals addr. Decoding always uses mappedAddr.
- R8: When both the special and expanded flags are set, $FD00-$FDFF selects nothing.
- R9: A write of register offset $3A programs the configuration cell (cfgProgEn high) only when lock bit 0 of offset $39 is clear.
- R10: Writes to the lock register and the configuration register are accepted only in the first WINDOW clock cycles after reset. While the special flag is set, this time limit does not apply.
- R11: When the expanded flag is set, selExt asserts for every access that no internal target claims. extShow asserts on reads that an internal target claims, but only when both the visibility flag and the expanded flag are set.
- R12: The mode register is at offset $38, with bit 7 boot ROM, bit 6 special, bit 5 expanded and bit 4 visibility. A write changes these flags only while the special flag is set. Otherwise the write is ignored.
- R13: No select and no extShow asserts unless rdEn or wrEn is high. At most one select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| modePinA | input | 1 | First mode pin, sampled during reset |
| modePinB | input | 1 | Second mode pin, sampled during reset |
| addr | input | 16 | CPU address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| vecFetch | input | 1 | Current read is a vector fetch |
| cfgCell | input | 8 | Content of the nonvolatile configuration cell |
| selRegs | output | 1 | Register block select |
| selEeprom | output | 1 | EEPROM select |
| selBootRom | output | 1 | Boot ROM select |
| selExt | output | 1 | External bus select |
| extShow | output | 1 | Internal read made visible on the external bus |
| cfgProgEn | output | 1 | Program the configuration cell with wrData |
| mappedAddr | output | 16 | Address after vector redirection |

## Verification
The bench builds the decoder with WINDOW set to 16 and keeps the register base at $1000. The short window lets a run of idle cycles close the write window, so a late write in a normal mode can be shown to be refused. The same late write is then shown to be accepted in a special mode. All four pin modes are exercised, and the model tracks the configuration cell across several resets. This shows the deferred page move, the disable bit and the lock bit through the selects seen after each reset.

// File: rtl/memmap_pkg.sv
`timescale 1ns/1ps
package memmap_pkg;
  localparam int MB_BOOT = 7;
  localparam int MB_SPEC = 6;
  localparam int MB_EXP  = 5;
  localparam int MB_VIS  = 4;

  typedef struct packed {
    logic       bootEn;
    logic       special;
    logic       expand;
    logic       visible;
    logic [7:0] cfgByte;
  } mapCtrl_t;
endpackage

// File: rtl/memMapCtrl.sv
`timescale 1ns/1ps
module memMapCtrl
  import memmap_pkg::*;
#(
  parameter int         WINDOW   = 64,
  parameter logic [5:0] OFF_MODE = 6'h38,
  parameter logic [5:0] OFF_LOCK = 6'h39,
  parameter logic [5:0] OFF_CFG  = 6'h3A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modePinA,
  input  logic       modePinB,
  input  logic       regWr,
  input  logic [5:0] regOff,
  input  logic [7:0] wrData,
  input  logic [7:0] cfgCell,
  output logic       cfgProgEn,
  output mapCtrl_t   ctrlOut
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cycCnt;
  logic             cfgLock;
  logic [7:0]       cfgActive;
  logic             bootEn, special, expand, visible;
  logic             timedOk, modeWr, lockWr;

  always_comb begin
    timedOk   = special || (cycCnt < CNT_MAX);
    modeWr    = regWr && (regOff == OFF_MODE) && special;
    lockWr    = regWr && (regOff == OFF_LOCK) && timedOk;
    cfgProgEn = rstN && regWr && (regOff == OFF_CFG) && timedOk && !cfgLock;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt    <= '0;
      cfgLock   <= 1'b1;
      cfgActive <= cfgCell;
      visible   <= 1'b0;
      unique case ({modePinA, modePinB})
        2'b11:   {bootEn, special, expand} <= 3'b001;
        2'b00:   {bootEn, special, expand} <= 3'b110;
        2'b10:   {bootEn, special, expand} <= 3'b011;
        default: {bootEn, special, expand} <= 3'b000;
      endcase
    end else begin
      if (cycCnt < CNT_MAX) cycCnt <= cycCnt + 1'b1;
      if (lockWr) cfgLock <= wrData[0];
      if (modeWr) begin
        bootEn  <= wrData[MB_BOOT];
        special <= wrData[MB_SPEC];
        expand  <= wrData[MB_EXP];
        visible <= wrData[MB_VIS];
      end
    end
  end

  always_comb begin
    ctrlOut.bootEn  = bootEn;
    ctrlOut.special = special;
    ctrlOut.expand  = expand;
    ctrlOut.visible = visible;
    ctrlOut.cfgByte = cfgActive;
  end
endmodule

// File: rtl/memMapPath.sv
`timescale 1ns/1ps
module memMapPath
  import memmap_pkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h1000
) (
  input  logic [15:0] addr,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        vecFetch,
  input  mapCtrl_t    ctrlIn,
  output logic        selRegs,
  output logic        selEeprom,
  output logic        selBootRom,
  output logic        selExt,
  output logic        extShow,
  output logic        regWr,
  output logic [15:0] mappedAddr
);
  localparam logic [9:0] VEC_TOP   = 10'h3FF;
  localparam logic [7:0] BOOT_PAGE = 8'hBF;
  localparam logic [7:0] HOLE_PAGE = 8'hFD;
  localparam logic [3:0] FORCE_PG  = 4'hF;

  logic       access, hitReg, hitEe, hitBoot, inHole, anyInt, eeOn;
  logic [3:0] eePage;

  always_comb begin
    mappedAddr = addr;
    if (vecFetch && ctrlIn.special && addr[15:6] == VEC_TOP)
      mappedAddr = {addr[15], 1'b0, addr[13:0]};
  end

  always_comb begin
    eeOn    = ctrlIn.expand ? ctrlIn.cfgByte[0]   : 1'b1;
    eePage  = ctrlIn.expand ? ctrlIn.cfgByte[7:4] : FORCE_PG;
    access  = rdEn || wrEn;
    hitReg  = mappedAddr[15:6] == REG_BASE[15:6];
    hitEe   = eeOn && mappedAddr[15:12] == eePage && mappedAddr[11:9] == 3'b111;
    hitBoot = ctrlIn.bootEn && mappedAddr[15:8] == BOOT_PAGE;
    inHole  = ctrlIn.special && ctrlIn.expand && mappedAddr[15:8] == HOLE_PAGE;
    anyInt  = hitReg || hitEe || hitBoot;

    selRegs    = access && hitReg;
    selEeprom  = access && hitEe && !hitReg;
    selBootRom = access && hitBoot && !hitReg && !hitEe;
    selExt     = access && ctrlIn.expand && !anyInt && !inHole;
    extShow    = rdEn && anyInt && ctrlIn.expand && ctrlIn.visible;
    regWr      = wrEn && hitReg;
  end
endmodule

// File: rtl/memMapDecoder.sv
`timescale 1ns/1ps
module memMapDecoder
  import memmap_pkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h1000,
  parameter int          WINDOW   = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modePinA,
  input  logic        modePinB,
  input  logic [15:0] addr,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        vecFetch,
  input  logic [7:0]  cfgCell,
  output logic        selRegs,
  output logic        selEeprom,
  output logic        selBootRom,
  output logic        selExt,
  output logic        extShow,
  output logic        cfgProgEn,
  output logic [15:0] mappedAddr
);
  mapCtrl_t ctrlBus;
  logic     regWr;

  memMapCtrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .modePinA(modePinA), .modePinB(modePinB),
    .regWr(regWr), .regOff(mappedAddr[5:0]), .wrData(wrData),
    .cfgCell(cfgCell), .cfgProgEn(cfgProgEn), .ctrlOut(ctrlBus)
  );

  memMapPath #(.REG_BASE(REG_BASE)) u_path (
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .vecFetch(vecFetch),
    .ctrlIn(ctrlBus), .selRegs(selRegs), .selEeprom(selEeprom),
    .selBootRom(selBootRom), .selExt(selExt), .extShow(extShow),
    .regWr(regWr), .mappedAddr(mappedAddr)
  );
endmodule

// File: rtl/memMapChecker.sv
`timescale 1ns/1ps
module memMapChecker
  import memmap_pkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h1000
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic        rdEn,
  input logic        wrEn,
  input logic        vecFetch,
  input logic        selRegs,
  input logic        selEeprom,
  input logic        selBootRom,
  input logic        selExt,
  input logic        extShow,
  input logic [15:0] mappedAddr,
  input mapCtrl_t    ctrlBus
);
  assert_onehot_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selRegs, selEeprom, selBootRom, selExt}));

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn || wrEn) |-> !(selRegs || selEeprom || selBootRom || selExt || extShow));

  assert_regwin_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[15:6] == REG_BASE[15:6]) |-> selRegs);

  assert_noext_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.expand |-> !selExt);

  assert_cfgheld_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(ctrlBus.cfgByte));

  assert_bootoff_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.bootEn |-> !selBootRom);

  assert_plain_R7: assert property (@(posedge clk) disable iff (!rstN)
    !vecFetch |-> mappedAddr == addr);

  assert_moved_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && ctrlBus.special && addr >= 16'hFFC0) |-> mappedAddr == addr - 16'h4000);

  assert_hole_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.special && ctrlBus.expand && mappedAddr[15:8] == 8'hFD) |-> !selExt);

  assert_modefix_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ctrlBus.special)) |->
      $stable({ctrlBus.bootEn, ctrlBus.special, ctrlBus.expand, ctrlBus.visible}));
endmodule

bind memMapDecoder memMapChecker #(.REG_BASE(REG_BASE)) u_memMapChecker (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
  .vecFetch(vecFetch), .selRegs(selRegs), .selEeprom(selEeprom),
  .selBootRom(selBootRom), .selExt(selExt), .extShow(extShow),
  .mappedAddr(mappedAddr), .ctrlBus(ctrlBus)
);

// File: tb/memMapDecoder_bench.sv
`timescale 1ns/1ps
module memMapDecoder_bench;
  localparam int WIN = 16;
  localparam int OFF_MODE = 'h38;
  localparam int OFF_LOCK = 'h39;
  localparam int OFF_CFG  = 'h3A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modePinA = 1'b0, modePinB = 1'b0;
  logic [15:0] addr = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0, vecFetch = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  cfgCell;
  logic        selRegs, selEeprom, selBootRom, selExt, extShow, cfgProgEn;
  logic [15:0] mappedAddr;

  int checks = 0, fails = 0;
  bit done = 0;
  int mBoot, mSpec, mExp, mVis, mLock, mCnt, mActive;
  int mCell = 'hFF;

  always #2 clk = ~clk;
  assign cfgCell = mCell[7:0];

  memMapDecoder #(.WINDOW(WIN)) u_memMapDecoder (
    .clk(clk), .rstN(rstN), .modePinA(modePinA), .modePinB(modePinB),
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .vecFetch(vecFetch), .cfgCell(cfgCell), .selRegs(selRegs),
    .selEeprom(selEeprom), .selBootRom(selBootRom), .selExt(selExt),
    .extShow(extShow), .cfgProgEn(cfgProgEn), .mappedAddr(mappedAddr)
  );

  function automatic int remap(int a, bit vec);
    if (vec && mSpec != 0 && a >= 'hFFC0) return a - 'h4000;
    return a;
  endfunction

  function automatic bit cfgAccepted(int m, bit wr);
    return wr && m >= 'h1000 && m <= 'h103F && (m - 'h1000) == OFF_CFG &&
           (mSpec != 0 || mCnt < WIN) && mLock == 0;
  endfunction

  function automatic logic [21:0] predict(int a, bit rd, bit wr, bit vec);
    int m, pg, base;
    bit acc, hReg, hEe, hBoot, hole, eeOn, sReg, sEe, sBoot, sExt, show;
    m = remap(a, vec);
    acc = rd || wr;
    if (mExp == 0) begin pg = 15; eeOn = 1; end
    else begin pg = (mActive >> 4) & 15; eeOn = (mActive & 1) != 0; end
    base  = pg * 4096 + 'hE00;
    hReg  = m >= 'h1000 && m <= 'h103F;
    hEe   = eeOn && m >= base && m <= base + 'h1FF;
    hBoot = mBoot != 0 && m >= 'hBF00 && m <= 'hBFFF;
    hole  = mSpec != 0 && mExp != 0 && m >= 'hFD00 && m <= 'hFDFF;
    sReg  = acc && hReg;
    sEe   = acc && !hReg && hEe;
    sBoot = acc && !hReg && !hEe && hBoot;
    sExt  = acc && mExp != 0 && !hReg && !hEe && !hBoot && !hole;
    show  = rd && (hReg || hEe || hBoot) && mExp != 0 && mVis != 0;
    return {sReg, sEe, sBoot, sExt, show, cfgAccepted(m, wr), m[15:0]};
  endfunction

  task automatic step(input int a, input bit rd, input bit wr, input int d,
                      input bit vec, input string tag);
    logic [21:0] exp, act;
    int m, off;
    addr = a[15:0]; rdEn = rd; wrEn = wr; wrData = d[7:0]; vecFetch = vec;
    #1;
    exp = predict(a, rd, wr, vec);
    act = {selRegs, selEeprom, selBootRom, selExt, extShow, cfgProgEn, mappedAddr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a[15:0], act, exp);
    end
    @(posedge clk);
    m = remap(a, vec);
    if (wr && m >= 'h1000 && m <= 'h103F) begin
      off = m - 'h1000;
      if (off == OFF_CFG && cfgAccepted(m, wr)) mCell = d & 'hFF;
      if (off == OFF_LOCK && (mSpec != 0 || mCnt < WIN)) mLock = d & 1;
      if (off == OFF_MODE && mSpec != 0) begin
        mBoot = (d >> 7) & 1; mSpec = (d >> 6) & 1;
        mExp  = (d >> 5) & 1; mVis  = (d >> 4) & 1;
      end
    end
    if (mCnt < WIN) mCnt++;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag);  step(a, 1, 0, 0, 0, tag); endtask
  task automatic vf(input int a, input string tag);  step(a, 1, 0, 0, 1, tag); endtask
  task automatic wreg(input int off, input int d, input string tag);
    step('h1000 + off, 0, 1, d, 0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "R13");
  endtask

  task automatic doReset(input bit pa, input bit pb);
    @(negedge clk);
    rstN = 1'b0; modePinA = pa; modePinB = pb;
    rdEn = 0; wrEn = 0; vecFetch = 0;
    repeat (3) @(negedge clk);
    case ({pa, pb})
      2'b11:   begin mBoot = 0; mSpec = 0; mExp = 1; end
      2'b00:   begin mBoot = 1; mSpec = 1; mExp = 0; end
      2'b10:   begin mBoot = 0; mSpec = 1; mExp = 1; end
      default: begin mBoot = 0; mSpec = 0; mExp = 0; end
    endcase
    mVis = 0; mLock = 1; mCnt = 0; mActive = mCell;
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // single-chip
    doReset(0, 1);
    idle(1);
    rd('hFE00, "R1"); rd('hFFFF, "R3"); rd('h8000, "R3");
    rd('h1000, "R2"); rd('h103F, "R2"); rd('h1040, "R2");
    rd('hBF00, "R6"); vf('hFFFE, "R7");
    // normal expanded, deferred config move
    doReset(1, 1);
    rd('hFE00, "R1"); rd('h8000, "R11"); rd('hFD00, "R8");
    vf('hFFFE, "R7"); rd('h1000, "R2");
    wreg(OFF_LOCK, 0, "R9"); wreg(OFF_CFG, 'h7F, "R5");
    rd('h7E00, "R5"); rd('hFE00, "R5");
    doReset(1, 1);
    rd('h7E00, "R4"); rd('h7FFF, "R4"); rd('hFE00, "R11");
    // locked write ignored
    wreg(OFF_CFG, 'h3F, "R9");
    doReset(1, 1);
    rd('h7E00, "R9"); rd('h3E00, "R9");
    // late write in normal mode ignored
    idle(WIN + 4);
    wreg(OFF_LOCK, 0, "R10"); wreg(OFF_CFG, 'h3F, "R10");
    doReset(1, 1);
    rd('h7E00, "R10"); rd('h3E00, "R10");
    // mode register locked in normal mode
    wreg(OFF_MODE, 'hE0, "R12"); rd('hBF00, "R12"); vf('hFFFE, "R12");
    // disable EEPROM
    wreg(OFF_LOCK, 0, "R9"); wreg(OFF_CFG, 'h7E, "R4");
    doReset(1, 1);
    rd('h7E00, "R4"); rd('hFE00, "R4");
    // bootstrap
    doReset(0, 0);
    rd('hFE00, "R1"); rd('h8000, "R3"); rd('hBF00, "R6"); rd('hBFFF, "R6");
    vf('hFFFE, "R7"); vf('hFFC0, "R7"); rd('hFFFE, "R7");
    wreg(OFF_MODE, 'hE6, "R12");
    rd('hFE00, "R4"); rd('hFD10, "R8"); step('hFD20, 0, 1, 5, 0, "R8");
    vf('hFFFE, "R7"); rd('h8000, "R11");
    wreg(OFF_MODE, 'hF6, "R11");
    rd('h1000, "R11"); rd('hBF00, "R11"); step('h1020, 0, 1, 1, 0, "R11");
    idle(WIN + 4);
    wreg(OFF_LOCK, 0, "R10"); wreg(OFF_CFG, 'h5F, "R10");
    doReset(1, 1);
    rd('h5E00, "R10"); rd('h7E00, "R10");
    // special test
    doReset(1, 0);
    rd('hBF00, "R1"); vf('hFFFE, "R7"); vf('hFFBE, "R7");
    rd('hFD00, "R8"); rd('h5E00, "R4"); idle(1);
    wreg(OFF_MODE, 'h20, "R12"); vf('hFFFE, "R12"); rd('hFD00, "R12");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule